// File: doc/BRIEF.md
# Majority-Voting Masked AND Gadget

This block multiplies two Boolean-masked bits over GF(2) while tolerating a bounded number of corrupted wire copies, and it never aborts. Each operand enters as a matrix of `D_ORDER+1` shares, and each share is carried in `2*K_FAULTS+1` identical copies. For every ordered share pair (i, j) the gadget forms the product of share i of the first operand and share j of the second operand once per copy. It hides that product behind `K_FAULTS+1` fresh random bits and reduces the copies of each product to a single bit by majority vote. Each output share is the XOR of its voted row of products. That share is then fanned out again into the full copy width, so the result can feed another gadget of the same kind.

A fault that hits one copy column of the inputs disturbs only that copy of each product. As long as no product sees more than `K_FAULTS` bad copies, every vote returns the fault-free value. The output sharing is then bit-for-bit the matrix a clean run would give. The random inputs are shared symmetrically between pair (i, j) and pair (j, i), and the diagonal pairs are unmasked. As a result all masks cancel when the output shares are summed.

A result is accepted on `inValid` and appears one clock later with `outValid`.

Top module: `maj_masked_and`

## Requirements
- R1: While `rst` is high and on the first sampling after it falls, `outValid` is 0 and every bit of `outMat` is 0.
- R2: With fault-free inputs, for every copy index c, the XOR over all shares i of `outMat[i*COPIES+c]` equals (XOR of the first operand's shares) AND (XOR of the second operand's shares). Matrices are flattened with bit index share*COPIES+copy, and COPIES = 2*K_FAULTS+1.
- R3: All COPIES bits of each output share are equal.
- R4: `outValid` is high exactly one cycle after `inValid` was high, and the result for each accepted input appears in that cycle.
- R5: The inputs may be corrupted by flipping any bits within at most K_FAULTS copy columns of `aMat` and `bMat`. With such corruption, `outMat` is identical to the result of the uncorrupted inputs, so every column still XORs to the product.
- R6: Output share i equals the XOR over j of (a_i AND b_j), XORed with a mask for every j != i. That mask is the XOR of bits `randBits[p*MASKS +: MASKS]`, where MASKS = K_FAULTS+1. The pair slot p is shared by (i, j) and (j, i): unordered pairs lo<hi are numbered from 0 in the order (0,1),(0,2),…,(1,2),…. Pairs with i == j get no mask.
- R7: While `inValid` is low, `outMat` keeps its value whatever `aMat`, `bMat` and `randBits` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input matrices and random bits are valid this cycle |
| aMat | input | (D_ORDER+1)*(2*K_FAULTS+1) | First operand, share-major copy matrix |
| bMat | input | (D_ORDER+1)*(2*K_FAULTS+1) | Second operand, share-major copy matrix |
| randBits | input | (D_ORDER+1)*D_ORDER/2*(K_FAULTS+1) | Fresh mask bits, MASKS per unordered share pair |
| outValid | output | 1 | `outMat` holds a new product |
| outMat | output | (D_ORDER+1)*(2*K_FAULTS+1) | Product sharing, share-major copy matrix |

## Verification
The embedded product check votes the per-column products of the input matrices. It therefore relies on at most K_FAULTS copy columns of `aMat` and `bMat` being corrupted in any accepted cycle, and on the rows of the uncorrupted inputs being copy-consistent. The stimulus builds each operand from clean shares replicated across all copies. It then picks at most K_FAULTS distinct columns and flips arbitrary bit patterns in both operands inside only those columns, so no product sees more than K_FAULTS bad copies. The voter check assumes nothing beyond unanimous copies, and the strobe checks assume `inValid` is held low during reset.

// File: rtl/maj_and_pkg.sv
package maj_and_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
  } gadgetStrobe_t;

  // Slot of unordered share pair (lo, hi), lo < hi, counted row by row
  function automatic int pairSlot(input int lo, input int hi, input int shares);
    return lo * shares - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

endpackage

// File: rtl/maj_and_voter.sv
module maj_and_voter #(
  parameter int COPIES = 3
) (
  input  logic [COPIES-1:0] copyBits,
  output logic              voted
);
  localparam int VOTE_MIN = (COPIES + 1) / 2;

  int onesCount;

  always_comb begin
    onesCount = 0;
    for (int c = 0; c < COPIES; c++) onesCount += int'(copyBits[c]);
    voted = (onesCount >= VOTE_MIN);
  end

  // Unanimous copies must pass through the vote untouched
  always_comb begin
    if (copyBits == '1) AST_UNANIMOUS_ONE : assert (voted);   // R5
    if (copyBits == '0) AST_UNANIMOUS_ZERO : assert (!voted); // R5
  end

endmodule

// File: rtl/maj_and_control.sv
module maj_and_control
  import maj_and_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output gadgetStrobe_t strobe,
  output logic          outValid
);

  always_comb strobe.load = inValid;

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  AST_VALID_FOLLOWS : assert property (@(posedge clk) disable iff (rst) inValid |=> outValid);  // R4
  AST_VALID_DROPS : assert property (@(posedge clk) disable iff (rst) !inValid |=> !outValid);  // R4

endmodule

// File: rtl/maj_and_datapath.sv
module maj_and_datapath
  import maj_and_pkg::*;
#(
  parameter int SHARES = 3,
  parameter int COPIES = 3,
  parameter int MASKS  = 2,
  parameter int RAND_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  gadgetStrobe_t              strobe,
  input  logic [SHARES*COPIES-1:0]   aMat,
  input  logic [SHARES*COPIES-1:0]   bMat,
  input  logic [RAND_W-1:0]          randBits,
  output logic [SHARES*COPIES-1:0]   outMat
);
  localparam int VOTE_MIN = (COPIES + 1) / 2;

  logic [SHARES*SHARES-1:0] votedProd;
  logic [SHARES-1:0]        shareSum;

  for (genvar i = 0; i < SHARES; i++) begin : g_rowA
    for (genvar j = 0; j < SHARES; j++) begin : g_colB
      logic              maskBit;
      logic [COPIES-1:0] crossCopy;

      if (i == j) begin : g_diag
        assign maskBit = 1'b0;
      end else begin : g_pair
        localparam int SLOT = (i < j) ? pairSlot(i, j, SHARES) : pairSlot(j, i, SHARES);
        assign maskBit = ^randBits[SLOT*MASKS +: MASKS];
      end

      for (genvar c = 0; c < COPIES; c++) begin : g_copy
        assign crossCopy[c] = (aMat[i*COPIES+c] & bMat[j*COPIES+c]) ^ maskBit;
      end

      maj_and_voter #(.COPIES(COPIES)) u_voter (
        .copyBits (crossCopy),
        .voted    (votedProd[i*SHARES+j])
      );
    end
  end

  always_comb begin
    for (int i = 0; i < SHARES; i++) begin
      shareSum[i] = 1'b0;
      for (int j = 0; j < SHARES; j++) shareSum[i] ^= votedProd[i*SHARES+j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outMat <= '0;
    end else if (strobe.load) begin
      for (int i = 0; i < SHARES; i++)
        for (int c = 0; c < COPIES; c++)
          outMat[i*COPIES+c] <= shareSum[i];
    end
  end

  // Reference product: vote the per-column unmasked products of the inputs
  logic [COPIES-1:0] colProd;
  logic              colVote;
  logic              outCol0;

  always_comb begin
    for (int c = 0; c < COPIES; c++) begin
      logic aSec, bSec;
      aSec = 1'b0;
      bSec = 1'b0;
      for (int i = 0; i < SHARES; i++) begin
        aSec ^= aMat[i*COPIES+c];
        bSec ^= bMat[i*COPIES+c];
      end
      colProd[c] = aSec & bSec;
    end
    colVote = ($countones(colProd) >= VOTE_MIN);
    outCol0 = 1'b0;
    for (int i = 0; i < SHARES; i++) outCol0 ^= outMat[i*COPIES];
  end

  AST_PRODUCT_CORRECT : assert property (@(posedge clk) disable iff (rst) strobe.load |=> (outCol0 == $past(colVote)));  // R2
  AST_HOLD_IDLE : assert property (@(posedge clk) disable iff (rst) !strobe.load |=> $stable(outMat));  // R7

endmodule

// File: rtl/maj_masked_and.sv
module maj_masked_and
  import maj_and_pkg::*;
#(
  parameter int D_ORDER  = 2,
  parameter int K_FAULTS = 1
) (
  input  logic                                                clk,
  input  logic                                                rst,
  input  logic                                                inValid,
  input  logic [(D_ORDER+1)*(2*K_FAULTS+1)-1:0]               aMat,
  input  logic [(D_ORDER+1)*(2*K_FAULTS+1)-1:0]               bMat,
  input  logic [((D_ORDER+1)*D_ORDER/2)*(K_FAULTS+1)-1:0]     randBits,
  output logic                                                outValid,
  output logic [(D_ORDER+1)*(2*K_FAULTS+1)-1:0]               outMat
);
  localparam int SHARES = D_ORDER + 1;
  localparam int COPIES = 2 * K_FAULTS + 1;
  localparam int MASKS  = K_FAULTS + 1;
  localparam int PAIRS  = SHARES * (SHARES - 1) / 2;
  localparam int RAND_W = PAIRS * MASKS;

  gadgetStrobe_t strobe;

  maj_and_control u_control (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  maj_and_datapath #(
    .SHARES (SHARES),
    .COPIES (COPIES),
    .MASKS  (MASKS),
    .RAND_W (RAND_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .aMat     (aMat),
    .bMat     (bMat),
    .randBits (randBits),
    .outMat   (outMat)
  );

endmodule

// File: tb/maj_masked_and_bench.sv
module maj_masked_and_bench;
  localparam int D_ORDER  = 2;
  localparam int K_FAULTS = 1;
  localparam int SHARES = D_ORDER + 1;
  localparam int COPIES = 2 * K_FAULTS + 1;
  localparam int MASKS  = K_FAULTS + 1;
  localparam int RAND_W = SHARES * (SHARES - 1) / 2 * MASKS;
  localparam int N      = SHARES * COPIES;

  typedef struct packed {
    logic [N-1:0] mat;
    logic         prod;
    logic         faulty;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [N-1:0] aMat = '0, bMat = '0;
  logic [RAND_W-1:0] randBits = '0;
  logic outValid;
  logic [N-1:0] outMat;

  int checks = 0, errors = 0;
  bit done = 0;
  expItem_t scoreQ[$];
  logic [N-1:0] lastExp = '0;
  int slotOf[SHARES][SHARES];

  always #5 clk = ~clk;

  maj_masked_and #(.D_ORDER(D_ORDER), .K_FAULTS(K_FAULTS)) u_maj_masked_and (
    .clk(clk), .rst(rst), .inValid(inValid), .aMat(aMat), .bMat(bMat),
    .randBits(randBits), .outValid(outValid), .outMat(outMat)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: called right after a falling edge
  task automatic sendItem(input bit withFaults, input bit forceOnes);
    logic [SHARES-1:0] aS, bS;
    logic [RAND_W-1:0] rv;
    logic [N-1:0] aM, bM, em;
    expItem_t it;
    int nf, start;
    aS = SHARES'($urandom);
    bS = SHARES'($urandom);
    if (forceOnes) begin
      if (^aS == 1'b0) aS[0] = ~aS[0];
      if (^bS == 1'b0) bS[0] = ~bS[0];
    end
    rv = RAND_W'($urandom);
    for (int i = 0; i < SHARES; i++) begin
      logic s;
      s = 1'b0;
      for (int j = 0; j < SHARES; j++) begin
        s ^= aS[i] & bS[j];
        if (i != j) s ^= ^rv[slotOf[i][j]*MASKS +: MASKS];
      end
      for (int c = 0; c < COPIES; c++) begin
        em[i*COPIES+c] = s;
        aM[i*COPIES+c] = aS[i];
        bM[i*COPIES+c] = bS[i];
      end
    end
    nf = withFaults ? 1 + int'($urandom % K_FAULTS) : 0;
    start = int'($urandom % COPIES);
    for (int f = 0; f < nf; f++) begin
      int col;
      logic [SHARES-1:0] fa, fb;
      col = (start + f) % COPIES;
      fa = SHARES'($urandom);
      fb = SHARES'($urandom);
      if (fa == '0) fa[0] = 1'b1;
      for (int i = 0; i < SHARES; i++) begin
        aM[i*COPIES+col] ^= fa[i];
        bM[i*COPIES+col] ^= fb[i];
      end
    end
    aMat = aM; bMat = bM; randBits = rv; inValid = 1'b1;
    it.mat = em; it.prod = (^aS) & (^bS); it.faulty = withFaults;
    scoreQ.push_back(it);
    lastExp = em;
  endtask

  // Monitor: compares each produced result against the scoreboard
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (scoreQ.size() == 0) begin
        check(1'b0, "R4", "unexpected outValid", 64'(outMat), 64'd0);
      end else begin
        expItem_t it;
        string req;
        bit rowsOk;
        it = scoreQ.pop_front();
        req = it.faulty ? "R5" : "R6";
        check(outMat == it.mat, req, "share matrix", 64'(outMat), 64'(it.mat));
        for (int c = 0; c < COPIES; c++) begin
          logic x;
          x = 1'b0;
          for (int i = 0; i < SHARES; i++) x ^= outMat[i*COPIES+c];
          check(x == it.prod, it.faulty ? "R5" : "R2", "column product", 64'(x), 64'(it.prod));
        end
        rowsOk = 1'b1;
        for (int i = 0; i < SHARES; i++)
          for (int c = 1; c < COPIES; c++)
            if (outMat[i*COPIES+c] != outMat[i*COPIES]) rowsOk = 1'b0;
        check(rowsOk, "R3", "row copies equal", 64'(outMat), 64'(it.mat));
      end
    end
  end

  initial begin
    int cnt;
    cnt = 0;
    for (int lo = 0; lo < SHARES; lo++) begin
      slotOf[lo][lo] = 0;
      for (int hi = lo + 1; hi < SHARES; hi++) begin
        slotOf[lo][hi] = cnt;
        slotOf[hi][lo] = cnt;
        cnt++;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", 64'(outValid), 64'd0);
    check(outMat == '0, "R1", "outMat in reset", 64'(outMat), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after reset", 64'(outValid), 64'd0);
    check(outMat == '0, "R1", "outMat after reset", 64'(outMat), 64'd0);

    // R4: a single accepted item gives a single one-cycle outValid
    sendItem(1'b0, 1'b1);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R4", "valid one cycle later", 64'(outValid), 64'd1);
    @(negedge clk);
    check(outValid == 1'b0, "R4", "valid drops", 64'(outValid), 64'd0);

    // R2/R6: clean items with gaps
    for (int n = 0; n < 40; n++) begin
      sendItem(1'b0, n % 4 == 0);
      @(negedge clk);
      if (n % 3 == 0) begin inValid = 1'b0; @(negedge clk); end
    end
    // R5: corrupted items back to back
    for (int n = 0; n < 150; n++) begin
      sendItem(1'b1, n % 5 == 0);
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check(scoreQ.size() == 0, "R4", "all results delivered", 64'(scoreQ.size()), 64'd0);

    // R7: idle inputs leave the output untouched
    for (int n = 0; n < 5; n++) begin
      aMat = N'($urandom); bMat = N'($urandom); randBits = RAND_W'($urandom);
      @(negedge clk);
    end
    check(outMat == lastExp, "R7", "hold while idle", 64'(outMat), 64'(lastExp));
    check(outValid == 1'b0, "R7", "no valid while idle", 64'(outValid), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule